// File: doc/BRIEF.md
# FIFO Page Replacement Tracker

This block follows which virtual pages currently occupy a fixed set of physical frames, and it replaces them oldest-first. Each clock cycle it may accept one page reference. The incoming page number is compared against every resident tag at the same time. The block then reports whether the reference was a hit or a fault. On a hit it names the frame that holds the page.

On a fault, a free frame is taken first. Free frames are filled in ascending order. Once every frame is occupied, the frame whose page arrived earliest is overwritten, and the displaced page is reported. A saturating counter totals the faults seen since reset.

Results are registered. They appear in the cycle after the reference is presented and last for one cycle. A new reference may follow in every cycle. Because the tag written by a fault is visible to the lookup in the next cycle, a page can be referenced back-to-back.

Top module: `fifo_page_tracker`

## Requirements
- R1: While `rst_n` is low at a clock edge, every frame becomes free, `fault_count` becomes 0, and `hit`, `fault`, `victim_valid`, `victim_page` and `frame_idx` are all 0 in the following cycle.
- R2: A reference whose page is resident gives `hit`=1 and `fault`=0 in the next cycle, with `frame_idx` equal to the frame holding that page. `fault_count` does not change.
- R3: A reference whose page is not resident while some frame is still free gives `fault`=1 and `victim_valid`=0 in the next cycle. `frame_idx` equals the number of frames filled before it (0, 1, 2, ...), so `frame_idx` always stays below `N_FRAMES`.
- R4: A non-resident reference with every frame occupied gives `fault`=1 and `victim_valid`=1. `victim_page` is the page that has been resident longest, and `frame_idx` is the frame it held. Whenever `victim_valid` is 0, `victim_page` is 0, and `victim_valid` is never 1 without `fault`.
- R5: Hits do not alter the replacement order. A page that was hit is still evicted in its original arrival position.
- R6: `hit` and `fault` are never 1 together. Exactly one of them is 1 in the cycle after `ref_valid`=1, and both are 0 in the cycle after `ref_valid`=0.
- R7: `fault_count` increases by one on each fault, together with `fault`. It holds at 2^`CNT_W`-1 once it reaches that value.
- R8: With three frames, the reference string 1,2,3,4,1,2,5,1,2,3,4,5 applied after reset leaves `fault_count` at 9.
- R9: With four frames, the same string leaves `fault_count` at 10, which is more faults than with three frames.
- R10: A page installed by a fault hits when it is referenced again in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_valid | input | 1 | A page reference is presented this cycle |
| ref_page | input | PAGE_W | Page number of the reference |
| hit | output | 1 | Previous reference was resident |
| fault | output | 1 | Previous reference was not resident |
| victim_valid | output | 1 | The fault displaced a resident page |
| victim_page | output | PAGE_W | Displaced page, 0 when none |
| frame_idx | output | max(1,clog2(N_FRAMES)) | Frame hit or filled, 0 when idle |
| fault_count | output | CNT_W | Saturating fault total |

## Verification
Eviction of the oldest page and saturation of the fault counter can fall in the same cycle. The four-frame instance is built with a 4-bit counter. A long stream of references over eight pages pushes it past 15 faults while every frame stays full. In every such cycle, the victim, the frame index and the held count are compared against a queue-based model. The second case that can coincide is installing a page and looking it up. Back-to-back references to the same page show whether the second lookup sees the tag written in the previous cycle.

// File: rtl/fpt_pkg.sv
// Package: shared types and helpers for the FIFO page replacement tracker.
// Assumes: nothing beyond IEEE 1800-2017.
package fpt_pkg;

    // Outcome of one reference, resolved combinationally in the top.
    typedef enum logic [1:0] {
        REF_NONE  = 2'd0,
        REF_HIT   = 2'd1,
        REF_FAULT = 2'd2
    } ref_kind_e;

    // Index width for a set of n entries, never below one bit.
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/fpt_tag_match.sv
// Module: parallel residency lookup.
// Compares the incoming page against every valid tag in the same cycle and
// returns a match vector, a hit flag and the matching frame index.
// Assumes: at most one valid tag holds a given page (guaranteed by the top,
// which only installs a page after a miss).
module fpt_tag_match #(
    parameter int N_FRAMES = 4,
    parameter int PAGE_W   = 8,
    localparam int IDX_W   = fpt_pkg::idx_width(N_FRAMES)
) (
    input  logic [N_FRAMES*PAGE_W-1:0] tags_flat,
    input  logic [N_FRAMES-1:0]        tag_valid,
    input  logic [PAGE_W-1:0]          page,
    output logic [N_FRAMES-1:0]        match_vec,
    output logic                       any_match,
    output logic [IDX_W-1:0]           match_idx
);

    // One comparator per frame.
    for (genvar g = 0; g < N_FRAMES; g++) begin : g_cmp
        assign match_vec[g] = tag_valid[g] &&
                              (tags_flat[g*PAGE_W +: PAGE_W] == page);
    end

    assign any_match = |match_vec;

    // Encode the (single) matching frame into an index.
    always_comb begin
        match_idx = '0;
        for (int i = 0; i < N_FRAMES; i++) begin
            if (match_vec[i]) match_idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/fpt_fifo_ptr.sv
// Module: arrival-order pointer and fill tracker.
// Points at the frame to fill next. While frames are free, that is the lowest
// free frame. Once all are full, it is the frame whose page arrived first.
// Advances by one (wrapping) on each installing fault.
// Assumes: adv is asserted only for a fault that writes a frame.
module fpt_fifo_ptr #(
    parameter int N_FRAMES = 4,
    localparam int IDX_W   = fpt_pkg::idx_width(N_FRAMES),
    localparam int FILL_W  = $clog2(N_FRAMES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [IDX_W-1:0] oldest_idx,
    output logic             all_full
);

    localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(N_FRAMES - 1);
    localparam logic [FILL_W-1:0] FULL_CNT = FILL_W'(N_FRAMES);

    logic [IDX_W-1:0]  ptr_q;
    logic [FILL_W-1:0] fill_q;

    // Circular pointer: moves to the next frame after each install.
    always_ff @(posedge clk) begin
        if (!rst_n)          ptr_q <= '0;
        else if (adv)        ptr_q <= (ptr_q == LAST_IDX) ? '0 : ptr_q + 1'b1;
    end

    // Fill counter: counts occupied frames up to N_FRAMES, then holds.
    always_ff @(posedge clk) begin
        if (!rst_n)                       fill_q <= '0;
        else if (adv && fill_q != FULL_CNT) fill_q <= fill_q + 1'b1;
    end

    assign oldest_idx = ptr_q;
    assign all_full   = (fill_q == FULL_CNT);

endmodule

// File: rtl/fpt_sat_counter.sv
// Module: saturating event counter.
// Counts inc pulses and holds at its all-ones value.
// Assumes: one increment per cycle at most.
module fpt_sat_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;

    // Increment unless already at the ceiling.
    always_ff @(posedge clk) begin
        if (!rst_n)                        cnt_q <= '0;
        else if (inc && cnt_q != CNT_MAX)  cnt_q <= cnt_q + 1'b1;
    end

    assign count = cnt_q;

endmodule

// File: rtl/fifo_page_tracker.sv
// Module: FIFO page replacement tracker (top).
// Holds N_FRAMES resident page tags. A reference is looked up in all frames
// at once. A miss installs the page in the frame named by the arrival-order
// pointer, displacing the earliest arrival once the set is full. Results are
// registered and valid for one cycle after the reference.
// Assumes: one reference per cycle; synchronous active-low reset.
module fifo_page_tracker
    import fpt_pkg::*;
#(
    parameter int N_FRAMES = 4,
    parameter int PAGE_W   = 8,
    parameter int CNT_W    = 16,
    localparam int IDX_W   = fpt_pkg::idx_width(N_FRAMES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_valid,
    input  logic [PAGE_W-1:0] ref_page,
    output logic              hit,
    output logic              fault,
    output logic              victim_valid,
    output logic [PAGE_W-1:0] victim_page,
    output logic [IDX_W-1:0]  frame_idx,
    output logic [CNT_W-1:0]  fault_count
);

    logic [PAGE_W-1:0]          tag_q [N_FRAMES];
    logic [N_FRAMES-1:0]        valid_q;
    logic [N_FRAMES*PAGE_W-1:0] tags_flat;
    logic [N_FRAMES-1:0]        match_vec;
    logic                       any_match;
    logic [IDX_W-1:0]           match_idx;
    logic [IDX_W-1:0]           oldest_idx;
    logic                       all_full;
    ref_kind_e                  kind;
    logic                       install;

    logic              hit_q;
    logic              fault_q;
    logic              vv_q;
    logic [PAGE_W-1:0] vp_q;
    logic [IDX_W-1:0]  fidx_q;

    // Flatten the tag array for the lookup module.
    for (genvar g = 0; g < N_FRAMES; g++) begin : g_flat
        assign tags_flat[g*PAGE_W +: PAGE_W] = tag_q[g];
    end

    fpt_tag_match #(
        .N_FRAMES (N_FRAMES),
        .PAGE_W   (PAGE_W)
    ) u_match (
        .tags_flat (tags_flat),
        .tag_valid (valid_q),
        .page      (ref_page),
        .match_vec (match_vec),
        .any_match (any_match),
        .match_idx (match_idx)
    );

    // Classify the current reference.
    always_comb begin
        if (!ref_valid)     kind = REF_NONE;
        else if (any_match) kind = REF_HIT;
        else                kind = REF_FAULT;
    end

    assign install = (kind == REF_FAULT);

    fpt_fifo_ptr #(
        .N_FRAMES (N_FRAMES)
    ) u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv        (install),
        .oldest_idx (oldest_idx),
        .all_full   (all_full)
    );

    // Per-frame tag and valid storage; written only when selected by a fault.
    for (genvar g = 0; g < N_FRAMES; g++) begin : g_frame
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tag_q[g]   <= '0;
                valid_q[g] <= 1'b0;
            end else if (install && oldest_idx == IDX_W'(g)) begin
                tag_q[g]   <= ref_page;
                valid_q[g] <= 1'b1;
            end
        end
    end

    fpt_sat_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (install),
        .count (fault_count)
    );

    // Register the per-reference result for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q   <= 1'b0;
            fault_q <= 1'b0;
            vv_q    <= 1'b0;
            vp_q    <= '0;
            fidx_q  <= '0;
        end else begin
            hit_q   <= (kind == REF_HIT);
            fault_q <= install;
            vv_q    <= install && all_full;
            vp_q    <= (install && all_full) ? tag_q[oldest_idx] : '0;
            case (kind)
                REF_HIT:   fidx_q <= match_idx;
                REF_FAULT: fidx_q <= oldest_idx;
                default:   fidx_q <= '0;
            endcase
        end
    end

    assign hit          = hit_q;
    assign fault        = fault_q;
    assign victim_valid = vv_q;
    assign victim_page  = vp_q;
    assign frame_idx    = fidx_q;

endmodule

// File: rtl/fpt_checker.sv
// Module: protocol checker for fifo_page_tracker, attached by bind.
// Observes the top's ports only.
module fpt_checker #(
    parameter int N_FRAMES = 4,
    parameter int PAGE_W   = 8,
    parameter int CNT_W    = 16,
    localparam int IDX_W   = fpt_pkg::idx_width(N_FRAMES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ref_valid,
    input logic              hit,
    input logic              fault,
    input logic              victim_valid,
    input logic [PAGE_W-1:0] victim_page,
    input logic [IDX_W-1:0]  frame_idx,
    input logic [CNT_W-1:0]  fault_count
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // R6
    hit_fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit && fault));

    // R6
    ref_gives_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_valid |=> (hit || fault));

    // R6
    idle_gives_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_valid |=> !(hit || fault));

    // R4
    victim_needs_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        victim_valid |-> fault);

    // R4
    no_victim_zero_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !victim_valid |-> (victim_page == '0));

    // R3
    frame_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit || fault) |-> (int'(frame_idx) < N_FRAMES));

    // R7
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && $past(fault_count) != CNT_MAX) |->
            (fault_count == $past(fault_count) + 1'b1));

    // R7
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fault |-> $stable(fault_count));

endmodule

bind fifo_page_tracker fpt_checker #(
    .N_FRAMES (N_FRAMES),
    .PAGE_W   (PAGE_W),
    .CNT_W    (CNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ref_valid    (ref_valid),
    .hit          (hit),
    .fault        (fault),
    .victim_valid (victim_valid),
    .victim_page  (victim_page),
    .frame_idx    (frame_idx),
    .fault_count  (fault_count)
);

// File: tb/fifo_page_tracker_tb.sv
// Behavioural reference: resident pages kept as a queue in arrival order.
module fpt_ref_model #(
    parameter int N     = 4,
    parameter int CNT_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_valid,
    input  int   ref_page,
    output int   e_hit,
    output int   e_fault,
    output int   e_vv,
    output int   e_vp,
    output int   e_frame,
    output int   e_cnt
);
    int pages[$];
    int frames[$];
    int cnt;

    always @(posedge clk) begin
        int found;
        if (!rst_n) begin
            pages.delete(); frames.delete(); cnt = 0;
            e_hit <= 0; e_fault <= 0; e_vv <= 0; e_vp <= 0; e_frame <= 0; e_cnt <= 0;
        end else begin
            e_hit <= 0; e_fault <= 0; e_vv <= 0; e_vp <= 0; e_frame <= 0;
            if (ref_valid) begin
                found = -1;
                foreach (pages[i]) if (pages[i] == ref_page) found = i;
                if (found >= 0) begin
                    e_hit   <= 1;
                    e_frame <= frames[found];
                end else begin
                    e_fault <= 1;
                    if (cnt < (1 << CNT_W) - 1) cnt = cnt + 1;
                    if (pages.size() < N) begin
                        e_frame <= pages.size();
                        frames.push_back(pages.size());
                        pages.push_back(ref_page);
                    end else begin
                        int vp, fr;
                        vp = pages.pop_front();
                        fr = frames.pop_front();
                        e_vv    <= 1;
                        e_vp    <= vp;
                        e_frame <= fr;
                        pages.push_back(ref_page);
                        frames.push_back(fr);
                    end
                end
            end
            e_cnt <= cnt;
        end
    end
endmodule

module fifo_page_tracker_tb;
    localparam int PAGE_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_valid = 1'b0;
    logic [PAGE_W-1:0] ref_page = '0;
    int   ref_page_i;
    int   errors = 0;
    int   checks = 0;
    bit   cmp_on = 1'b0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;  // 200 MHz
    assign ref_page_i = int'(ref_page);

    // Four frames, small counter so saturation is reachable.
    logic a_hit, a_fault, a_vv;
    logic [PAGE_W-1:0] a_vp;
    logic [1:0] a_fr;
    logic [3:0] a_cnt;
    fifo_page_tracker #(.N_FRAMES(4), .PAGE_W(PAGE_W), .CNT_W(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_page(ref_page),
        .hit(a_hit), .fault(a_fault), .victim_valid(a_vv), .victim_page(a_vp),
        .frame_idx(a_fr), .fault_count(a_cnt));

    // Three frames.
    logic b_hit, b_fault, b_vv;
    logic [PAGE_W-1:0] b_vp;
    logic [1:0] b_fr;
    logic [7:0] b_cnt;
    fifo_page_tracker #(.N_FRAMES(3), .PAGE_W(PAGE_W), .CNT_W(8)) u_dut3 (
        .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_page(ref_page),
        .hit(b_hit), .fault(b_fault), .victim_valid(b_vv), .victim_page(b_vp),
        .frame_idx(b_fr), .fault_count(b_cnt));

    int ma_hit, ma_fault, ma_vv, ma_vp, ma_fr, ma_cnt;
    int mb_hit, mb_fault, mb_vv, mb_vp, mb_fr, mb_cnt;
    fpt_ref_model #(.N(4), .CNT_W(4)) u_ma (
        .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_page(ref_page_i),
        .e_hit(ma_hit), .e_fault(ma_fault), .e_vv(ma_vv), .e_vp(ma_vp),
        .e_frame(ma_fr), .e_cnt(ma_cnt));
    fpt_ref_model #(.N(3), .CNT_W(8)) u_mb (
        .clk(clk), .rst_n(rst_n), .ref_valid(ref_valid), .ref_page(ref_page_i),
        .e_hit(mb_hit), .e_fault(mb_fault), .e_vv(mb_vv), .e_vp(mb_vp),
        .e_frame(mb_fr), .e_cnt(mb_cnt));

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the models, away from the rising edge.
    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            chk("R2", "4f hit",   int'(a_hit),   ma_hit);
            chk("R3", "4f fault", int'(a_fault), ma_fault);
            chk("R4", "4f victim_valid", int'(a_vv), ma_vv);
            chk("R4", "4f victim_page",  int'(a_vp), ma_vp);
            chk("R3", "4f frame_idx",    int'(a_fr), ma_fr);
            chk("R7", "4f fault_count",  int'(a_cnt), ma_cnt);
            chk("R2", "3f hit",   int'(b_hit),   mb_hit);
            chk("R3", "3f fault", int'(b_fault), mb_fault);
            chk("R4", "3f victim_valid", int'(b_vv), mb_vv);
            chk("R4", "3f victim_page",  int'(b_vp), mb_vp);
            chk("R3", "3f frame_idx",    int'(b_fr), mb_fr);
            chk("R7", "3f fault_count",  int'(b_cnt), mb_cnt);
        end
    end

    task automatic do_ref(input int p);
        @(negedge clk);
        ref_valid = 1'b1;
        ref_page  = PAGE_W'(p);
    endtask

    task automatic idle();
        @(negedge clk);
        ref_valid = 1'b0;
        ref_page  = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; ref_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(150000 * 5);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int seq[12] = '{1, 2, 3, 4, 1, 2, 5, 1, 2, 3, 4, 5};
        int seed = 12345;
        do_reset();
        // R1: reset state at the ports.
        chk("R1", "hit",   int'(a_hit | b_hit), 0);
        chk("R1", "fault", int'(a_fault | b_fault), 0);
        chk("R1", "victim", int'(a_vv) + int'(a_vp), 0);
        chk("R1", "count", int'(a_cnt) + int'(b_cnt), 0);
        cmp_on = 1'b1;

        // R8 / R9: the classic string, back-to-back.
        foreach (seq[i]) do_ref(seq[i]);
        idle();
        chk("R8", "3-frame faults", int'(b_cnt), 9);
        chk("R9", "4-frame faults", int'(a_cnt), 10);

        // R5: a hit must not refresh arrival order.
        do_reset();
        do_ref(10); do_ref(11); do_ref(12); do_ref(13);
        do_ref(10);
        do_ref(14);
        chk("R5", "hit on oldest", int'(a_hit), 1);
        chk("R2", "hit frame", int'(a_fr), 0);
        idle();
        chk("R5", "victim_valid", int'(a_vv), 1);
        chk("R5", "victim page still oldest", int'(a_vp), 10);
        chk("R4", "victim frame", int'(a_fr), 0);

        // R10: install then immediately re-reference.
        do_ref(20);
        do_ref(20);
        chk("R10", "first is fault", int'(a_fault), 1);
        chk("R4", "evicts 11", int'(a_vp), 11);
        idle();
        chk("R10", "second is hit", int'(a_hit), 1);
        chk("R10", "hit frame", int'(a_fr), 1);
        idle();
        chk("R6", "no result after idle", int'(a_hit | a_fault), 0);

        // Long mixed stream; drives the 4-bit counter into saturation (R7).
        for (int n = 0; n < 3000; n++) begin
            seed = seed * 1103515245 + 12345;
            if (((seed >>> 16) & 3) == 0) idle();
            else do_ref((seed >>> 20) & 7);
        end
        idle();
        idle();
        chk("R7", "saturated count", int'(a_cnt), 15);

        // R1: mid-run reset clears the count.
        do_reset();
        chk("R1", "count after reset", int'(a_cnt), 0);
        do_ref(3);
        idle();
        chk("R3", "first fill frame 0", int'(a_fr), 0);
        chk("R3", "no victim on fill", int'(a_vv), 0);

        cmp_on = 1'b0;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule